// File: doc/BRIEF.md
# Serial-to-Parallel Word Assembler

The block collects a one-bit serial stream into a four-bit parallel word. A one-cycle Start pulse opens a capture. The block then takes one serial bit on each of the next four rising clock edges. The first bit taken becomes the most significant bit of the word. When the fourth bit is in, the Done flag rises and the assembled word stays on the parallel output until the next capture begins.

Internally a two-state Moore controller (idle and capturing) works alongside a small cycle counter. Start clears that counter, and the counter reaching its terminal value ends the capture. A shift register advances only while the controller is capturing.

There is no back-pressure. While Done is low the block consumes the serial input on every clock edge, so the sender must present a fresh bit every cycle. A Start issued in the same cycle that Done first reads high begins the next word with no gap.

Top module: `s2p_conv`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it is released, done_o reads 1 and word_o reads 0.
- R2: A high start_i sampled while idle (done_o = 1) makes done_o read 0 after that clock edge.
- R3: After the edge that accepts start_i, done_o stays 0 for exactly four clock cycles and then returns to 1, provided no further start_i arrives during the capture.
- R4: The word shown when done_o returns to 1 holds the four serial bits taken during the capture, most significant first: the bit sampled on the first capture edge is in word_o[3] and the bit sampled on the last is in word_o[0].
- R5: While idle, ser_i has no effect: word_o and done_o stay unchanged until a new start_i is accepted.
- R6: A high start_i sampled during a capture, before its final bit, restarts the bit count. That edge still takes a bit, and four more capture edges follow it. The word is the last four bits taken.
- R7: A high start_i sampled on the final bit edge of a capture does not extend it. The word completes on that edge, done_o returns to 1, and the block remains idle afterwards until a new start_i arrives.
- R8: Over a long run of random words, including back-to-back captures with Start on the first idle cycle, every completed word equals the last four serial bits taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| start_i | input | 1 | Opens or restarts a capture |
| ser_i | input | 1 | Serial data bit, sampled every capture cycle |
| word_o | output | WORD_W (4) | Assembled parallel word |
| done_o | output | 1 | High while idle and the word is valid |

## Verification
Done falls one edge after Start is accepted and rises four edges later. A restart mid-capture moves that rise to four edges after the restarting edge. The word is final on the same edge where Done rises. Inputs are driven one nanosecond after a rising edge, so each edge sees settled values. Directed checks read the outputs just after the edge they concern. A behavioural model advances on each rising edge and is compared against the outputs on every falling edge.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAPT = 1'b1
  } s2p_state_e;
endpackage

// File: rtl/s2p_ctrl.sv
module s2p_ctrl
  import s2p_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       last_i,
  output s2p_state_e state_o,
  output logic       capt_o,
  output logic       done_o
);
  s2p_state_e state_q, state_d;

  always_comb begin
    state_d = ST_IDLE;
    if ((state_q == ST_IDLE && start_i) || (state_q == ST_CAPT && !last_i))
      state_d = ST_CAPT;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
  assign capt_o  = (state_q == ST_CAPT);
  assign done_o  = (state_q == ST_IDLE);

  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_CAPT)); // R2
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAPT && last_i) |=> (state_q == ST_IDLE)); // R7
  AST_CAPT_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAPT && !last_i) |=> (state_q == ST_CAPT)); // R6
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE)); // R5
endmodule

// File: rtl/s2p_bitcnt.sv
module s2p_bitcnt #(
  parameter int WORD_W = 4,
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (inc_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(cnt_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && inc_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3
endmodule

// File: rtl/s2p_shreg.sv
module s2p_shreg #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst)       q_q <= '0;
    else if (en_i) q_q <= {q_q[WORD_W-2:0], bit_i};
  end

  assign q_o = q_q;

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(q_q)); // R5
  AST_SR_ENTRY: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (q_q[0] == $past(bit_i))); // R4
  AST_SR_MOVE: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (q_q[WORD_W-1:1] == $past(q_q[WORD_W-2:0]))); // R4
endmodule

// File: rtl/s2p_conv.sv
module s2p_conv
  import s2p_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              ser_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  s2p_state_e       state;
  logic             capt;
  logic             last;
  logic [CNT_W-1:0] cnt;

  s2p_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .last_i  (last),
    .state_o (state),
    .capt_o  (capt),
    .done_o  (done_o)
  );

  s2p_bitcnt #(.WORD_W(WORD_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (start_i),
    .inc_i  (capt),
    .cnt_o  (cnt),
    .last_o (last)
  );

  s2p_shreg #(.WORD_W(WORD_W)) u_sr (
    .clk   (clk),
    .rst   (rst),
    .en_i  (capt),
    .bit_i (ser_i),
    .q_o   (word_o)
  );

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (cnt == '0)); // R3
  AST_DONE_RISE_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(capt)); // R3
endmodule

// File: tb/s2p_conv_tb.sv
module s2p_conv_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         ser_i = 1'b0;
  logic [W-1:0] word_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  s2p_conv #(.WORD_W(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ser_i   (ser_i),
    .word_o  (word_o),
    .done_o  (done_o)
  );

  // behavioural reference: capture flag, bits taken since last restart, word
  bit       m_capt = 0;
  int       m_taken = 0;
  bit [3:0] m_word = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_capt = 0; m_taken = 0; m_word = '0;
    end else if (!m_capt) begin
      if (start_i) begin m_capt = 1; m_taken = 0; end
    end else begin
      m_word = {m_word[2:0], ser_i};
      if (m_taken == 3)   begin m_capt = 0; m_taken = 0; end
      else if (start_i)   m_taken = 0;
      else                m_taken = m_taken + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(done_o == !m_capt, "R3 done vs model", done_o, !m_capt);
      chk(word_o == m_word, "R4 word vs model", word_o, m_word);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // drive inputs, then wait until just after the next rising edge
  task automatic step(input bit s, input bit d);
    start_i = s;
    ser_i   = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    bit [3:0] w;
    bit [3:0] hist;
    bit [3:0] held;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(done_o == 1'b1, "R1 done in reset", done_o, 1);
    chk(word_o == '0, "R1 word in reset", word_o, 0);
    rst = 1'b0;
    step(0, 1);
    chk(done_o == 1'b1, "R1 done after reset", done_o, 1);
    chk(word_o == '0, "R1 word after reset", word_o, 0);

    // directed word 1011
    w = 4'b1011;
    step(1, 0);
    chk(done_o == 1'b0, "R2 done falls", done_o, 0);
    for (int i = 3; i >= 0; i--) begin
      if (i != 0) begin
        step(0, w[i]);
        chk(done_o == 1'b0, "R3 done low in capture", done_o, 0);
      end else begin
        step(0, w[i]);
      end
    end
    chk(done_o == 1'b1, "R3 done back after four bits", done_o, 1);
    chk(word_o == w, "R4 msb first", word_o, w);

    // idle with ser_i toggling
    for (int i = 0; i < 10; i++) begin
      step(0, i[0]);
      chk(word_o == w, "R5 word held while idle", word_o, w);
      chk(done_o == 1'b1, "R5 done held while idle", done_o, 1);
    end

    // restart mid-capture: start on the third capture edge
    step(1, 0);
    step(0, 1);
    step(0, 1);
    step(1, 1);
    w = 4'b0110;
    for (int i = 3; i >= 0; i--) begin
      chk(done_o == 1'b0, "R6 capture extended", done_o, 0);
      step(0, w[i]);
    end
    chk(done_o == 1'b1, "R6 done after extension", done_o, 1);
    chk(word_o == w, "R6 word is last four bits", word_o, w);

    // start on the final bit edge does not extend
    step(1, 0);
    step(0, 1);
    step(0, 0);
    step(0, 0);
    step(1, 1);
    chk(done_o == 1'b1, "R7 done on final edge", done_o, 1);
    chk(word_o == 4'b1001, "R7 word completes", word_o, 4'b1001);
    step(0, 0);
    chk(done_o == 1'b1, "R7 start swallowed, stays idle", done_o, 1);
    chk(word_o == 4'b1001, "R7 word kept", word_o, 4'b1001);

    // random words, mostly back-to-back
    for (int n = 0; n < 120; n++) begin
      int guard;
      if (($urandom % 4) == 0) step(0, 1'($urandom));
      held = word_o;
      step(1, 1'($urandom));
      hist = '0;
      guard = 0;
      while (!done_o && guard < 10) begin
        bit b;
        b = 1'($urandom);
        hist = {hist[2:0], b};
        step(0, b);
        guard++;
      end
      chk(guard == 4, "R8 four capture cycles", guard, 4);
      chk(word_o == hist, "R8 random word", word_o, hist);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule